// File: doc/BRIEF.md
# Edge-Triggered Interrupt Flag Controller

This block gathers eight interrupt sources into a single 8-bit pending-flag register. Each flag has its own set condition. Three flags latch one-cycle overflow pulses from timers. One latches a serial-data-valid pulse. The other four watch external lines for edges. The line inputs are asynchronous, so each passes through a two-flop synchronizer and an edge detector first. Several flags are shared by more than one line. One flag takes its edge polarity from a control input.

An 8-bit enable register sits beside the flags. Software writes both registers through a simple write port and can read both at any time. A flag stays set until software writes a 0 to its bit. The block drives one request line to the CPU. That line is high when any flag is set and its enable bit is also set. A disabled source still records its flag, but it does not raise the request.

Top module: `irq_flag_ctrl`

## Requirements
- R1: While reset is asserted, and right after it is released, the flag register, the enable register and the request output are all 0.
- R2: A high level on the main-timer, counter-1 or counter-2 overflow input sets flag bit 0, 1 or 2 respectively. The flag is visible one clock after the sampling edge.
- R3: A falling edge on any of the four keypad lines sets flag bit 3, three clocks after the edge that first samples the new level. A rising edge on these lines has no effect.
- R4: A high level on the serial-data-valid input sets flag bit 4, one clock later.
- R5: Flag bit 5 follows the external line. When the polarity input is 1, a rising edge sets it. When the polarity input is 0, a falling edge sets it. The opposite edge has no effect, and changing the polarity input alone sets nothing.
- R6: A falling edge on either the FSK data line or the call-waiting line sets flag bit 6. Rising edges on these lines have no effect.
- R7: A rising edge on either the buffer-full line or the tone-valid line sets flag bit 7. Falling edges on these lines have no effect.
- R8: A flag write clears every flag bit whose data bit is 0 and leaves every flag bit whose data bit is 1 unchanged.
- R9: When a set event and a clearing write hit the same flag bit in the same cycle, the flag ends up set.
- R10: An enable write loads all 8 bits of the enable register. With no write, the register holds its value.
- R11: The request output is the OR, over the 8 bits, of (flag AND enable). A 0 enable bit never stops its flag from being set.
- R12: A set flag stays set until a flag write clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| tmr_ovf_i | input | 1 | Main timer overflow pulse (synchronous) |
| cnt1_ovf_i | input | 1 | Counter 1 overflow pulse (synchronous) |
| cnt2_ovf_i | input | 1 | Counter 2 overflow pulse (synchronous) |
| sdv_pulse_i | input | 1 | Serial-data-valid pulse (synchronous) |
| key_pin_i | input | 4 | Keypad lines, asynchronous, idle high |
| ext_pin_i | input | 1 | External line for flag 5, asynchronous |
| ext_pol_i | input | 1 | Flag 5 polarity: 1 = rising edge, 0 = falling edge |
| fsk_data_i | input | 1 | FSK data line, asynchronous, idle high |
| cw_det_i | input | 1 | Call-waiting detect line, asynchronous, idle high |
| buf_full_i | input | 1 | Serial buffer-full line, asynchronous, idle low |
| tone_valid_i | input | 1 | Tone decoder valid line, asynchronous, idle low |
| flag_wr_i | input | 1 | Flag write strobe (0 bits clear, 1 bits keep) |
| mask_wr_i | input | 1 | Enable register write strobe |
| wdata_i | input | 8 | Write data |
| flag_o | output | 8 | Pending flag register |
| mask_o | output | 8 | Enable register |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The properties assume three things about the inputs. The overflow and data-valid pulses arrive already synchronous to the clock. Reset is held long enough to fill the synchronizers. Line inputs rest at their idle levels while reset is asserted. The stimulus meets these rules in three ways. It drives every input only on the falling clock edge. It holds all lines idle during a multi-cycle reset. It applies each line change as its own operation, and it waits the full synchronizer and edge-detector latency before checking, so the expected flags never depend on edges that are still in flight.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;

    // Flag register layout (bit positions are decoded by software)
    localparam int FLAG_W     = 8;
    localparam int F_TMR      = 0;
    localparam int F_CNT1     = 1;
    localparam int F_CNT2     = 2;
    localparam int F_KEY      = 3;
    localparam int F_SDV      = 4;
    localparam int F_EXT      = 5;
    localparam int F_MODEM    = 6;
    localparam int F_DONE     = 7;

    // Asynchronous line bundle layout
    localparam int KEY_N      = 4;
    localparam int A_KEY0     = 0;
    localparam int A_EXT      = KEY_N;
    localparam int A_FSK      = KEY_N + 1;
    localparam int A_CW       = KEY_N + 2;
    localparam int A_BUF      = KEY_N + 3;
    localparam int A_TONE     = KEY_N + 4;
    localparam int ASYNC_W    = KEY_N + 5;

    typedef struct packed {
        logic [FLAG_W-1:0] flag;
        logic [FLAG_W-1:0] mask;
    } irq_state_t;

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [W-1:0] stg1_d, stg1_q;
    logic [W-1:0] stg2_d, stg2_q;

    always_comb begin
        stg1_d = async_i;
        stg2_d = stg1_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            stg1_q <= RST_VAL;
            stg2_q <= RST_VAL;
        end else begin
            stg1_q <= stg1_d;
            stg2_q <= stg2_d;
        end
    end

    assign sync_o = stg2_q;

endmodule

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] lvl_i,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);

    logic [W-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = lvl_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            prev_q <= RST_VAL;
        end else begin
            prev_q <= prev_d;
        end
    end

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign rise_o[i] =  lvl_i[i] & ~prev_q[i];
        assign fall_o[i] = ~lvl_i[i] &  prev_q[i];
    end

endmodule

// File: rtl/irq_set_merge.sv
module irq_set_merge
    import irq_flag_pkg::*;
(
    input  logic [ASYNC_W-1:0] rise_i,
    input  logic [ASYNC_W-1:0] fall_i,
    input  logic               ext_pol_i,
    input  logic               tmr_ovf_i,
    input  logic               cnt1_ovf_i,
    input  logic               cnt2_ovf_i,
    input  logic               sdv_pulse_i,
    output logic [FLAG_W-1:0]  set_o
);

    always_comb begin
        set_o          = '0;
        set_o[F_TMR]   = tmr_ovf_i;
        set_o[F_CNT1]  = cnt1_ovf_i;
        set_o[F_CNT2]  = cnt2_ovf_i;
        set_o[F_KEY]   = |fall_i[A_KEY0 +: KEY_N];
        set_o[F_SDV]   = sdv_pulse_i;
        set_o[F_EXT]   = ext_pol_i ? rise_i[A_EXT] : fall_i[A_EXT];
        set_o[F_MODEM] = fall_i[A_FSK] | fall_i[A_CW];
        set_o[F_DONE]  = rise_i[A_BUF] | rise_i[A_TONE];
    end

endmodule

// File: rtl/irq_flag_regs.sv
module irq_flag_regs
    import irq_flag_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [FLAG_W-1:0] set_i,
    input  logic              flag_wr_i,
    input  logic              mask_wr_i,
    input  logic [FLAG_W-1:0] wdata_i,
    output logic [FLAG_W-1:0] flag_o,
    output logic [FLAG_W-1:0] mask_o
);

    irq_state_t st_d, st_q;

    always_comb begin
        logic [FLAG_W-1:0] keep;
        st_d    = st_q;
        keep    = flag_wr_i ? wdata_i : '1;
        // set events take priority over a same-cycle clear
        st_d.flag = (st_q.flag & keep) | set_i;
        if (mask_wr_i) begin
            st_d.mask = wdata_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flag;
    assign mask_o = st_q.mask;

endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
    import irq_flag_pkg::*;
#(
    parameter logic EXT_IDLE = 1'b1
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       tmr_ovf_i,
    input  logic       cnt1_ovf_i,
    input  logic       cnt2_ovf_i,
    input  logic       sdv_pulse_i,
    input  logic [3:0] key_pin_i,
    input  logic       ext_pin_i,
    input  logic       ext_pol_i,
    input  logic       fsk_data_i,
    input  logic       cw_det_i,
    input  logic       buf_full_i,
    input  logic       tone_valid_i,
    input  logic       flag_wr_i,
    input  logic       mask_wr_i,
    input  logic [7:0] wdata_i,
    output logic [7:0] flag_o,
    output logic [7:0] mask_o,
    output logic       irq_o
);

    localparam logic [ASYNC_W-1:0] IDLE_LVL =
        {1'b0, 1'b0, 1'b1, 1'b1, EXT_IDLE, {KEY_N{1'b1}}};

    logic [ASYNC_W-1:0] raw_lines;
    logic [ASYNC_W-1:0] sync_lines;
    logic [ASYNC_W-1:0] rise;
    logic [ASYNC_W-1:0] fall;
    logic [FLAG_W-1:0]  set_vec;
    logic [FLAG_W-1:0]  flag_q;
    logic [FLAG_W-1:0]  mask_q;

    assign raw_lines = {tone_valid_i, buf_full_i, cw_det_i, fsk_data_i,
                        ext_pin_i, key_pin_i};

    irq_sync #(.W(ASYNC_W), .RST_VAL(IDLE_LVL)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .async_i(raw_lines),
        .sync_o (sync_lines)
    );

    irq_edge_det #(.W(ASYNC_W), .RST_VAL(IDLE_LVL)) u_edge (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .lvl_i (sync_lines),
        .rise_o(rise),
        .fall_o(fall)
    );

    irq_set_merge u_merge (
        .rise_i     (rise),
        .fall_i     (fall),
        .ext_pol_i  (ext_pol_i),
        .tmr_ovf_i  (tmr_ovf_i),
        .cnt1_ovf_i (cnt1_ovf_i),
        .cnt2_ovf_i (cnt2_ovf_i),
        .sdv_pulse_i(sdv_pulse_i),
        .set_o      (set_vec)
    );

    irq_flag_regs u_regs (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .set_i    (set_vec),
        .flag_wr_i(flag_wr_i),
        .mask_wr_i(mask_wr_i),
        .wdata_i  (wdata_i),
        .flag_o   (flag_q),
        .mask_o   (mask_q)
    );

    assign flag_o = flag_q;
    assign mask_o = mask_q;
    assign irq_o  = |(flag_q & mask_q);

endmodule

// File: rtl/irq_flag_ctrl_chk.sv
module irq_flag_ctrl_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       tmr_ovf_i,
    input logic       cnt1_ovf_i,
    input logic       cnt2_ovf_i,
    input logic       sdv_pulse_i,
    input logic       flag_wr_i,
    input logic       mask_wr_i,
    input logic [7:0] wdata_i,
    input logic [7:0] flag_o,
    input logic [7:0] mask_o,
    input logic       irq_o
);

    p_reset_clear_r1: assert property (@(posedge clk_i)
        !rst_ni |=> (flag_o == 8'h00 && mask_o == 8'h00 && !irq_o));

    p_timer_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tmr_ovf_i |=> flag_o[0]);

    p_cnt1_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt1_ovf_i |=> flag_o[1]);

    p_cnt2_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt2_ovf_i |=> flag_o[2]);

    p_sdv_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sdv_pulse_i |=> flag_o[4]);

    p_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag_wr_i && !wdata_i[0] && !tmr_ovf_i) |=> !flag_o[0]);

    p_set_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag_wr_i && !wdata_i[4] && sdv_pulse_i) |=> flag_o[4]);

    p_mask_load_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mask_wr_i |=> (mask_o == $past(wdata_i)));

    p_mask_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !mask_wr_i |=> $stable(mask_o));

    p_irq_off_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mask_o == 8'h00) |-> !irq_o);

    p_irq_on_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((flag_o & mask_o) != 8'h00) |-> irq_o);

    p_sticky_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((($past(flag_o) & ($past(flag_wr_i) ? $past(wdata_i) : 8'hFF))
                   & ~flag_o) == 8'h00));

endmodule

bind irq_flag_ctrl irq_flag_ctrl_chk u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tmr_ovf_i  (tmr_ovf_i),
    .cnt1_ovf_i (cnt1_ovf_i),
    .cnt2_ovf_i (cnt2_ovf_i),
    .sdv_pulse_i(sdv_pulse_i),
    .flag_wr_i  (flag_wr_i),
    .mask_wr_i  (mask_wr_i),
    .wdata_i    (wdata_i),
    .flag_o     (flag_o),
    .mask_o     (mask_o),
    .irq_o      (irq_o)
);

// File: tb/sim_irq_flag_ctrl.sv
module sim_irq_flag_ctrl;

    localparam time CLK_PERIOD = 10ns;
    localparam int  N_RAND     = 400;

    logic       clk_i = 1'b0;
    logic       rst_ni = 1'b0;
    logic       tmr_ovf_i = 1'b0, cnt1_ovf_i = 1'b0, cnt2_ovf_i = 1'b0, sdv_pulse_i = 1'b0;
    logic [3:0] key_pin_i = 4'hF;
    logic       ext_pin_i = 1'b1, ext_pol_i = 1'b0;
    logic       fsk_data_i = 1'b1, cw_det_i = 1'b1;
    logic       buf_full_i = 1'b0, tone_valid_i = 1'b0;
    logic       flag_wr_i = 1'b0, mask_wr_i = 1'b0;
    logic [7:0] wdata_i = 8'h00;
    logic [7:0] flag_o, mask_o;
    logic       irq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [7:0] exp_flag = 8'h00;
    logic [7:0] exp_mask = 8'h00;
    // line bundle: [3:0] keys, 4 ext, 5 fsk, 6 cw, 7 buf, 8 tone
    logic [8:0] lines = 9'b0_0111_1111;

    always #(CLK_PERIOD/2) clk_i = ~clk_i;

    irq_flag_ctrl u0 (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .tmr_ovf_i(tmr_ovf_i), .cnt1_ovf_i(cnt1_ovf_i), .cnt2_ovf_i(cnt2_ovf_i),
        .sdv_pulse_i(sdv_pulse_i), .key_pin_i(key_pin_i), .ext_pin_i(ext_pin_i),
        .ext_pol_i(ext_pol_i), .fsk_data_i(fsk_data_i), .cw_det_i(cw_det_i),
        .buf_full_i(buf_full_i), .tone_valid_i(tone_valid_i),
        .flag_wr_i(flag_wr_i), .mask_wr_i(mask_wr_i), .wdata_i(wdata_i),
        .flag_o(flag_o), .mask_o(mask_o), .irq_o(irq_o)
    );

    function automatic logic [7:0] line_sets(logic [8:0] o, logic [8:0] n, logic pol);
        logic [8:0] f = o & ~n;
        logic [8:0] r = ~o & n;
        logic [7:0] s = 8'h00;
        s[3] = |f[3:0];
        s[5] = pol ? r[4] : f[4];
        s[6] = f[5] | f[6];
        s[7] = r[7] | r[8];
        return s;
    endfunction

    function automatic logic want_irq(logic [7:0] f, logic [7:0] m);
        return |(f & m);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_all(string req);
        check(req, {24'h0, flag_o}, {24'h0, exp_flag});
        check(req, {24'h0, mask_o}, {24'h0, exp_mask});
        check(req, {31'h0, irq_o},  {31'h0, want_irq(exp_flag, exp_mask)});
    endtask

    // drive a new line bundle, wait synchronizer + edge latency, check
    task automatic set_lines(logic [8:0] n, string req);
        exp_flag = exp_flag | line_sets(lines, n, ext_pol_i);
        lines = n;
        {tone_valid_i, buf_full_i, cw_det_i, fsk_data_i, ext_pin_i, key_pin_i} = n;
        repeat (3) @(posedge clk_i);
        @(negedge clk_i);
        check_all(req);
    endtask

    // one-cycle pulses {sdv,cnt2,cnt1,tmr} with optional flag write
    task automatic pulse(logic [3:0] p, logic wr, logic [7:0] d, string req);
        logic [7:0] s = {3'b000, p[3], 1'b0, p[2:0]};
        {sdv_pulse_i, cnt2_ovf_i, cnt1_ovf_i, tmr_ovf_i} = p;
        flag_wr_i = wr;
        wdata_i   = d;
        exp_flag  = (exp_flag & (wr ? d : 8'hFF)) | s;
        @(posedge clk_i);
        @(negedge clk_i);
        {sdv_pulse_i, cnt2_ovf_i, cnt1_ovf_i, tmr_ovf_i} = 4'h0;
        flag_wr_i = 1'b0;
        check_all(req);
    endtask

    task automatic wr_mask(logic [7:0] d, string req);
        mask_wr_i = 1'b1;
        wdata_i   = d;
        exp_mask  = d;
        @(posedge clk_i);
        @(negedge clk_i);
        mask_wr_i = 1'b0;
        check_all(req);
    endtask

    task automatic clear_all();
        pulse(4'h0, 1'b1, 8'h00, "R8");
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0917));
        repeat (3) @(posedge clk_i);
        @(negedge clk_i);
        check_all("R1");
        rst_ni = 1'b1;
        @(negedge clk_i);
        check_all("R1");

        // R2 / R4 timer and data-valid pulses
        pulse(4'b0001, 1'b0, 8'h00, "R2");
        pulse(4'b0110, 1'b0, 8'h00, "R2");
        pulse(4'b1000, 1'b0, 8'h00, "R4");
        // R12 sticky across idle cycles
        repeat (5) @(posedge clk_i);
        @(negedge clk_i);
        check_all("R12");
        // R8 write of 1s keeps, 0s clear
        pulse(4'h0, 1'b1, 8'hFF, "R8");
        pulse(4'h0, 1'b1, 8'hF0, "R8");
        clear_all();

        // R3 keypad: rising no effect, falling sets
        set_lines(9'b0_0111_1011, "R3");
        set_lines(9'b0_0111_1111, "R3");
        clear_all();
        set_lines(9'b0_0111_1111 & ~9'h008, "R3");
        set_lines(9'b0_0111_1111, "R3");

        // R5 polarity select
        clear_all();
        ext_pol_i = 1'b1;
        @(negedge clk_i);
        set_lines(9'b0_0110_1111, "R5");
        check({31'h0, flag_o[5]}, 32'h0, 32'h0);
        set_lines(9'b0_0111_1111, "R5");
        ext_pol_i = 1'b0;
        @(negedge clk_i);
        check_all("R5");
        clear_all();
        set_lines(9'b0_0110_1111, "R5");

        // R6 modem lines
        clear_all();
        set_lines(9'b0_0101_1111, "R6");
        set_lines(9'b0_0111_1111, "R6");
        clear_all();
        set_lines(9'b0_0011_1111, "R6");
        set_lines(9'b0_0111_1111, "R6");

        // R7 done strobes
        clear_all();
        set_lines(9'b1_0111_1111, "R7");
        clear_all();
        set_lines(9'b0_0111_1111, "R7");
        set_lines(9'b0_1111_1111, "R7");
        clear_all();
        set_lines(9'b0_0111_1111, "R7");

        // R9 set wins over clear
        pulse(4'b1001, 1'b1, 8'h00, "R9");

        // R10 / R11 enable register and request
        wr_mask(8'h00, "R11");
        pulse(4'b0010, 1'b0, 8'h00, "R11");
        wr_mask(8'h02, "R10");
        wr_mask(8'hA5, "R10");
        clear_all();

        // random mix
        for (int i = 0; i < N_RAND; i++) begin
            int op = $urandom % 6;
            case (op)
                0: pulse(4'($urandom), 1'($urandom), 8'($urandom), "RND");
                1: set_lines(9'($urandom), "RND");
                2: pulse(4'h0, 1'b1, 8'($urandom), "RND");
                3: wr_mask(8'($urandom), "RND");
                4: begin
                    ext_pol_i = ~ext_pol_i;
                    @(negedge clk_i);
                    check_all("RND");
                end
                default: begin
                    @(negedge clk_i);
                    check_all("RND");
                end
            endcase
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule